// File: doc/BRIEF.md
# Multi-Mode PWM Output Channel

This block drives one pulse-width-modulated pin in one of three ways. In the free-running mode the channel counts prescaler ticks with its own counter, so both frequency and duty are set per channel. In the phase-placed mode it follows a shared up-counting timebase and opens its pulse a programmable offset into each period. In the two center modes it follows a shared up/down timebase and produces a pulse centered on the top of the count, with an optional dead time that trims either the rising half or the falling half of the pulse.

Period, duty, offset and dead time are written into shadow registers at any time through a write strobe. The working copies take the shadow values only at a period start, or at once when a force strobe is given, so a running waveform never shows a half-updated setting. Mode and output polarity are taken only while the channel is disabled. A one-cycle flag marks each period start.

Top module: `pwm_mm_channel`

## Requirements
- R1: After reset, and while `enable` is low, `pwm_out` sits at the inactive level (low for active-high polarity, high for active-low) and `boundary` is low; reset selects active-high polarity and the free-running mode (mode code 0).
- R2: In mode 0 an internal counter advances on each cycle with `tick` high, runs from 0 to period-1 and wraps; the output is active while the counter is below the duty. Offset and dead-time values have no effect in this mode.
- R3: In mode 0 a duty of 0 keeps the output inactive for the whole period, and a duty at or above the period keeps it active for the whole period.
- R4: In mode 1, on each tick the shared count is sampled; the output is active while the sampled count is at least the offset and below offset plus duty. A period starts when the count sampled with a tick is 0.
- R5: In modes 2 and 3, on each tick the shared count and direction (`tb_down`=1 while counting down) are sampled; with top value T equal to the period setting and h = floor(duty/2), the output is active on the up side while count+h > T and on the down side while count+h >= T, giving 2h active ticks in each 2T-2 tick period. A period starts when count 1 is sampled with `tb_down` low.
- R6: Dead time D shortens the center pulse by D ticks: mode 3 raises the up-side threshold by D (later leading edge), mode 2 raises the down-side threshold by D (earlier trailing edge).
- R7: Values written with `cfg_wr` go to the shadow registers and reach the working registers only at the next period start (or on a force strobe); while disabled the working registers follow the shadow every cycle.
- R8: A `force_match` pulse while enabled copies the shadow values at once, restarts the internal counter at 0 in mode 0, and raises `boundary` in the following cycle.
- R9: `mode_sel` and `active_high` are captured only while `enable` is low; changes made while enabled have no effect on the output.
- R10: In mode 0, with `freeze_en` and `dbg_halt` both high, the internal counter holds and the output holds its level.
- R11: `boundary` is high for exactly the cycle after each period start or force strobe taken while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel run enable |
| tick | input | 1 | Prescaler tick, one cycle per count step |
| dbg_halt | input | 1 | Debug halt request |
| freeze_en | input | 1 | Let `dbg_halt` stop the internal counter |
| mode_sel | input | 2 | 0 free-running, 1 phase-placed, 2 center with trailing dead time, 3 center with leading dead time |
| active_high | input | 1 | 1 for active-high output |
| cfg_wr | input | 1 | Write strobe for the shadow registers |
| period_in | input | W | Period (mode 0/1) or timebase top value (modes 2/3) |
| duty_in | input | W | Duty in ticks |
| phase_in | input | W | Leading-edge offset for mode 1 |
| dead_in | input | W | Dead time for modes 2/3 |
| tb_count | input | W | Shared timebase count |
| tb_down | input | 1 | Shared timebase direction, 1 = down |
| force_match | input | 1 | Apply shadow values at once |
| pwm_out | output | 1 | PWM pin |
| boundary | output | 1 | Period-start flag |

## Verification
A stale working register shows up as a wrong pulse width or offset within one period of the point where the shadow should have been taken, and a counter that skips or stalls shifts every later edge, so the bench compares the pin and the flag against its own model on every cycle rather than only at period ends. A wrong load moment (too early on a write, missed on a force) shows as a pin difference inside the period in which the write was made. A lost sample of the shared count shows in the first tick after it, and directed active-tick counts per period tie each mode to its closed-form width.

// File: rtl/pwm_mm_pkg.sv
package pwm_mm_pkg;

   typedef enum logic [1:0] {
      PM_FREE      = 2'd0,
      PM_PHASE     = 2'd1,
      PM_CTR_TRAIL = 2'd2,
      PM_CTR_LEAD  = 2'd3
   } pm_mode_e;

   localparam int unsigned PM_NFIELD = 4;
   localparam int unsigned PM_F_PER  = 0;
   localparam int unsigned PM_F_DUTY = 1;
   localparam int unsigned PM_F_PH   = 2;
   localparam int unsigned PM_F_DEAD = 3;

endpackage

// File: rtl/pwm_mm_regs.sv
module pwm_mm_regs
   import pwm_mm_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 cfg_wr,
   input  logic                 load,
   input  logic [1:0]           mode_sel,
   input  logic                 active_high,
   input  logic [PM_NFIELD-1:0][W-1:0] fld_in,
   output logic [PM_NFIELD-1:0][W-1:0] fld_act,
   output pm_mode_e             mode_q,
   output logic                 pol_q
);

   logic [PM_NFIELD-1:0][W-1:0] fld_shd;

   // Each field has a shadow copy written by software and a working copy
   // that only moves on a load event.
   for (genvar gi = 0; gi < PM_NFIELD; gi++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fld_shd[gi] <= '0;
            fld_act[gi] <= '0;
         end else begin
            if (cfg_wr) fld_shd[gi] <= fld_in[gi];
            if (load)   fld_act[gi] <= fld_shd[gi];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_FREE;
         pol_q  <= 1'b1;
      end else if (!enable) begin
         mode_q <= pm_mode_e'(mode_sel);
         pol_q  <= active_high;
      end
   end

endmodule

// File: rtl/pwm_mm_timebase.sv
module pwm_mm_timebase
   import pwm_mm_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         tick,
   input  logic         run,
   input  logic         force_match,
   input  pm_mode_e     mode_q,
   input  logic [W-1:0] per_a,
   input  logic [W-1:0] tb_count,
   input  logic         tb_down,
   output logic [W-1:0] cnt,
   output logic [W-1:0] tb_q,
   output logic         dn_q,
   output logic         en_q,
   output logic         load,
   output logic         bnd_q
);

   localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

   logic wrap_evt;
   logic last_cnt;

   assign last_cnt = ({1'b0, cnt} + ONE_X) >= {1'b0, per_a};

   always_comb begin
      wrap_evt = 1'b0;
      if (enable && tick) begin
         unique case (mode_q)
            PM_FREE:  wrap_evt = run && last_cnt;
            PM_PHASE: wrap_evt = (tb_count == '0);
            default:  wrap_evt = (tb_count == W'(1)) && !tb_down;
         endcase
      end
   end

   assign load = !enable || force_match || wrap_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         tb_q  <= '0;
         dn_q  <= 1'b0;
         en_q  <= 1'b0;
         bnd_q <= 1'b0;
      end else begin
         en_q  <= enable;
         bnd_q <= enable && (force_match || wrap_evt);
         if (!enable) begin
            cnt  <= '0;
            tb_q <= '0;
            dn_q <= 1'b0;
         end else begin
            if (mode_q == PM_FREE) begin
               if (force_match)      cnt <= '0;
               else if (tick && run) cnt <= last_cnt ? '0 : cnt + W'(1);
            end
            if (tick) begin
               tb_q <= tb_count;
               dn_q <= tb_down;
            end
         end
      end
   end

endmodule

// File: rtl/pwm_mm_shaper.sv
module pwm_mm_shaper
   import pwm_mm_pkg::*;
#(
   parameter int unsigned W         = 16,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic         en_q,
   input  logic         pol_q,
   input  pm_mode_e     mode_q,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] tb_q,
   input  logic         dn_q,
   input  logic [W-1:0] per_a,
   input  logic [W-1:0] duty_a,
   input  logic [W-1:0] phase_a,
   input  logic [W-1:0] dead_a,
   output logic         pwm_out
);

   localparam int unsigned WX = W + 1;

   logic          free_on;
   logic          phase_on;
   logic          ctr_on;
   logic [WX-1:0] ph_end;
   logic          raw;

   assign free_on  = cnt < duty_a;
   assign ph_end   = {1'b0, phase_a} + {1'b0, duty_a};
   assign phase_on = (tb_q >= phase_a) && ({1'b0, tb_q} < ph_end);

   if (CENTER_EN) begin : g_center
      logic [W-1:0]  half;
      logic [WX-1:0] pos;
      logic [WX-1:0] up_thr;
      logic [WX-1:0] dn_thr;
      assign half   = duty_a >> 1;
      assign pos    = {1'b0, tb_q} + {1'b0, half};
      assign up_thr = {1'b0, per_a} + ((mode_q == PM_CTR_LEAD)  ? {1'b0, dead_a} : '0);
      assign dn_thr = {1'b0, per_a} + ((mode_q == PM_CTR_TRAIL) ? {1'b0, dead_a} : '0);
      assign ctr_on = dn_q ? (pos >= dn_thr) : (pos > up_thr);
   end else begin : g_no_center
      assign ctr_on = 1'b0;
   end

   always_comb begin
      unique case (mode_q)
         PM_FREE:  raw = free_on;
         PM_PHASE: raw = phase_on;
         default:  raw = ctr_on;
      endcase
   end

   assign pwm_out = pol_q ~^ (en_q && raw);

endmodule

// File: rtl/pwm_mm_channel.sv
module pwm_mm_channel
   import pwm_mm_pkg::*;
#(
   parameter int unsigned W         = 16,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         tick,
   input  logic         dbg_halt,
   input  logic         freeze_en,
   input  logic [1:0]   mode_sel,
   input  logic         active_high,
   input  logic         cfg_wr,
   input  logic [W-1:0] period_in,
   input  logic [W-1:0] duty_in,
   input  logic [W-1:0] phase_in,
   input  logic [W-1:0] dead_in,
   input  logic [W-1:0] tb_count,
   input  logic         tb_down,
   input  logic         force_match,
   output logic         pwm_out,
   output logic         boundary
);

   if (W < 2 || W > 32) begin : g_bad_width
      $error("pwm_mm_channel: W must lie in 2..32");
   end

   logic [PM_NFIELD-1:0][W-1:0] fld_in;
   logic [PM_NFIELD-1:0][W-1:0] fld_act;
   logic [W-1:0] per_a, duty_a, phase_a, dead_a;
   logic [W-1:0] cnt, tb_q;
   logic         dn_q, en_q, load, pol_q, run;
   pm_mode_e     mode_q;

   assign fld_in[PM_F_PER]  = period_in;
   assign fld_in[PM_F_DUTY] = duty_in;
   assign fld_in[PM_F_PH]   = phase_in;
   assign fld_in[PM_F_DEAD] = dead_in;

   assign per_a   = fld_act[PM_F_PER];
   assign duty_a  = fld_act[PM_F_DUTY];
   assign phase_a = fld_act[PM_F_PH];
   assign dead_a  = fld_act[PM_F_DEAD];

   assign run = !(freeze_en && dbg_halt);

   pwm_mm_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
      .load(load), .mode_sel(mode_sel), .active_high(active_high),
      .fld_in(fld_in), .fld_act(fld_act), .mode_q(mode_q), .pol_q(pol_q)
   );

   pwm_mm_timebase #(.W(W)) u_tb (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .run(run),
      .force_match(force_match), .mode_q(mode_q), .per_a(per_a),
      .tb_count(tb_count), .tb_down(tb_down), .cnt(cnt), .tb_q(tb_q),
      .dn_q(dn_q), .en_q(en_q), .load(load), .bnd_q(boundary)
   );

   pwm_mm_shaper #(.W(W), .CENTER_EN(CENTER_EN)) u_shape (
      .en_q(en_q), .pol_q(pol_q), .mode_q(mode_q), .cnt(cnt), .tb_q(tb_q),
      .dn_q(dn_q), .per_a(per_a), .duty_a(duty_a), .phase_a(phase_a),
      .dead_a(dead_a), .pwm_out(pwm_out)
   );

endmodule

// File: rtl/pwm_mm_checker.sv
module pwm_mm_checker #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         enable,
   input logic         force_match,
   input logic         freeze_en,
   input logic         dbg_halt,
   input logic [1:0]   mode_q,
   input logic         pol_q,
   input logic         en_q,
   input logic [W-1:0] cnt,
   input logic [W-1:0] per_a,
   input logic [W-1:0] duty_a,
   input logic [W-1:0] phase_a,
   input logic [W-1:0] tb_q,
   input logic         load,
   input logic         pwm_out,
   input logic         boundary
);

   a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (pwm_out == !pol_q));

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == 2'd0 && per_a != '0) |-> (cnt < per_a));

   a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == 2'd0 && duty_a == '0) |-> (pwm_out == !pol_q));

   a_r3_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == 2'd0 && per_a != '0 && duty_a >= per_a) |-> (pwm_out == pol_q));

   a_r4_before_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == 2'd1 && tb_q < phase_a) |-> (pwm_out == !pol_q));

   a_r7_load_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(duty_a) || !$stable(per_a)) |-> $past(load));

   a_r8_force_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && force_match) |=> boundary);

   a_r9_pol_locked: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(pol_q));

   a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && freeze_en && dbg_halt && !force_match && mode_q == 2'd0) |=> $stable(cnt));

   a_r11_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |-> $past(enable));

endmodule

bind pwm_mm_channel pwm_mm_checker #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .force_match(force_match),
   .freeze_en(freeze_en), .dbg_halt(dbg_halt), .mode_q(mode_q), .pol_q(pol_q),
   .en_q(en_q), .cnt(cnt), .per_a(per_a), .duty_a(duty_a), .phase_a(phase_a),
   .tb_q(tb_q), .load(load), .pwm_out(pwm_out), .boundary(boundary)
);

// File: tb/test_pwm_mm_channel.sv
`timescale 1ns/1ps
module test_pwm_mm_channel;

   localparam int W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 0, tick = 0, dbg_halt = 0, freeze_en = 0;
   logic [1:0] mode_sel = 2'd0;
   logic active_high = 1'b1, cfg_wr = 0, force_match = 0, tb_down = 0;
   logic [W-1:0] period_in = '0, duty_in = '0, phase_in = '0, dead_in = '0, tb_count = '0;
   logic pwm_out, boundary;

   int errors = 0, checks = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   pwm_mm_channel #(.W(W)) i_pwm_mm_channel (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .dbg_halt(dbg_halt),
      .freeze_en(freeze_en), .mode_sel(mode_sel), .active_high(active_high),
      .cfg_wr(cfg_wr), .period_in(period_in), .duty_in(duty_in), .phase_in(phase_in),
      .dead_in(dead_in), .tb_count(tb_count), .tb_down(tb_down),
      .force_match(force_match), .pwm_out(pwm_out), .boundary(boundary)
   );

   // ---------------- behavioural reference ----------------
   int s_per, s_duty, s_ph, s_dead, a_per, a_duty, a_ph, a_dead;
   int m_mode, m_cnt, m_tb;
   bit m_pol, m_dn, m_en, m_bnd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_per = 0; s_duty = 0; s_ph = 0; s_dead = 0;
         a_per = 0; a_duty = 0; a_ph = 0; a_dead = 0;
         m_mode = 0; m_cnt = 0; m_tb = 0; m_pol = 1; m_dn = 0; m_en = 0; m_bnd = 0;
      end else begin
         bit wrap, ld, halted;
         halted = freeze_en && dbg_halt;
         wrap = 0;
         if (enable && tick) begin
            if (m_mode == 0)      wrap = !halted && (m_cnt + 1 >= a_per);
            else if (m_mode == 1) wrap = (tb_count == 0);
            else                  wrap = (tb_count == 1) && !tb_down;
         end
         ld = !enable || force_match || wrap;
         m_bnd = enable && (force_match || wrap);
         if (!enable) begin
            m_cnt = 0; m_tb = 0; m_dn = 0;
         end else begin
            if (m_mode == 0) begin
               if (force_match)           m_cnt = 0;
               else if (tick && !halted)  m_cnt = wrap ? 0 : m_cnt + 1;
            end
            if (tick) begin m_tb = tb_count; m_dn = tb_down; end
         end
         m_en = enable;
         if (ld) begin a_per = s_per; a_duty = s_duty; a_ph = s_ph; a_dead = s_dead; end
         if (cfg_wr) begin s_per = period_in; s_duty = duty_in; s_ph = phase_in; s_dead = dead_in; end
         if (!enable) begin m_mode = mode_sel; m_pol = active_high; end
      end
   end

   function automatic bit exp_out();
      bit raw;
      int h, lead, trail;
      if (!m_en) return !m_pol;
      case (m_mode)
         0: raw = m_cnt < a_duty;
         1: raw = (m_tb >= a_ph) && (m_tb < a_ph + a_duty);
         default: begin
            h = a_duty / 2;
            lead  = (m_mode == 3) ? a_dead : 0;
            trail = (m_mode == 2) ? a_dead : 0;
            raw = m_dn ? (m_tb + h >= a_per + trail) : (m_tb + h > a_per + lead);
         end
      endcase
      return m_pol ? raw : !raw;
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // bench timebase: kind 0 idle, 1 up modulo b_n, 2 up/down with top b_p
   int b_kind = 0, b_n = 1, b_p = 2, b_cnt = 0;
   bit b_dn = 0;

   task automatic adv_tb();
      if (b_kind == 1) b_cnt = (b_cnt + 1) % b_n;
      else if (b_kind == 2) begin
         if (!b_dn) begin
            if (b_cnt >= b_p) begin b_dn = 1; b_cnt = b_p - 1; end
            else b_cnt++;
         end else begin
            if (b_cnt <= 2) begin b_dn = 0; b_cnt = 1; end
            else b_cnt--;
         end
      end
      tb_count = W'(b_cnt);
      tb_down  = b_dn;
   endtask

   task automatic step(bit tk);
      tick = tk;
      if (tk) adv_tb();
      @(negedge clk);
      chk(cur_req, pwm_out, exp_out(), "pin");
      chk("R11", boundary, m_bnd, "boundary");
      cfg_wr = 0;
      force_match = 0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step(1'b1);
   endtask

   task automatic write_cfg(int per, int duty, int ph, int dead);
      period_in = W'(per); duty_in = W'(duty); phase_in = W'(ph); dead_in = W'(dead);
      cfg_wr = 1;
      step(1'b1);
   endtask

   task automatic restart(int mode, bit pol, int per, int duty, int ph, int dead);
      enable = 0;
      step(1'b0);
      mode_sel = 2'(mode); active_high = pol;
      write_cfg(per, duty, ph, dead);
      step(1'b0);
      enable = 1;
   endtask

   task automatic count_active(int n, bit pol, int exp, string req);
      int c = 0;
      for (int i = 0; i < n; i++) begin
         step(1'b1);
         if (pwm_out == pol) c++;
      end
      chk(req, c, exp, "active ticks per period");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk("R1", pwm_out, 0, "pin in reset");
      chk("R1", boundary, 0, "flag in reset");
      rst_n = 1;
      step(1'b0);
      chk("R1", pwm_out, 0, "pin disabled");

      // R2: free-running, offset and dead time set but ignored
      cur_req = "R2";
      restart(0, 1, 8, 3, 4, 5);
      run(20);
      count_active(8, 1, 3, "R2");
      for (int i = 0; i < 16; i++) step(i % 2 == 0);
      count_active(8, 1, 3, "R2");

      // R7: new duty waits for period start
      cur_req = "R7";
      run(2);
      write_cfg(8, 6, 0, 0);
      run(10);
      count_active(8, 1, 6, "R7");

      // R3: duty 0 and duty equal to period
      cur_req = "R3";
      write_cfg(8, 0, 0, 0);
      run(10);
      count_active(8, 1, 0, "R3");
      write_cfg(8, 8, 0, 0);
      run(10);
      count_active(8, 1, 8, "R3");

      // R8: force strobe applies at once
      cur_req = "R8";
      run(3);
      period_in = W'(5); duty_in = W'(2); cfg_wr = 1;
      step(1'b1);
      force_match = 1;
      step(1'b1);
      chk("R8", boundary, 1, "flag after force");
      chk("R8", pwm_out, 1, "pin after force");
      count_active(5, 1, 2, "R8");

      // R10: freeze holds the counter and pin
      cur_req = "R10";
      run(1);
      freeze_en = 1; dbg_halt = 1;
      step(1'b1);
      begin
         bit held;
         held = pwm_out;
         for (int i = 0; i < 6; i++) begin
            step(1'b1);
            chk("R10", pwm_out, held, "pin while frozen");
         end
      end
      dbg_halt = 0; freeze_en = 0;
      run(6);

      // R9: polarity and mode ignored while enabled
      cur_req = "R9";
      active_high = 0; mode_sel = 2'd1;
      run(4);
      count_active(5, 1, 2, "R9");
      restart(0, 0, 5, 2, 0, 0);
      run(6);
      count_active(5, 0, 2, "R9");

      // R4: phase-placed on an up counter
      cur_req = "R4";
      b_kind = 1; b_n = 20; b_cnt = 19;
      restart(1, 1, 20, 7, 5, 0);
      run(30);
      count_active(20, 1, 7, "R4");

      // R5: center aligned, no dead time
      cur_req = "R5";
      b_kind = 2; b_p = 10; b_cnt = 1; b_dn = 0;
      restart(2, 1, 10, 6, 0, 0);
      run(30);
      count_active(18, 1, 6, "R5");

      // R6: dead time on the trailing side (mode 2) and leading side (mode 3)
      cur_req = "R6";
      restart(2, 1, 10, 6, 0, 2);
      run(30);
      count_active(18, 1, 4, "R6");
      restart(3, 1, 10, 6, 0, 2);
      run(30);
      count_active(18, 1, 4, "R6");
      restart(3, 0, 10, 8, 0, 3);
      run(30);
      count_active(18, 0, 5, "R6");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule